// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is the slave side of a two-wire serial control port. It sits in front of a bank of 16-bit configuration registers. The block samples the serial clock and data lines with its own fast system clock, passing both through synchronisers first. It recognises start, repeated-start and stop conditions. When the first byte carries its 7-bit device address, it acknowledges. It then takes a one-byte register address, followed by data words sent high byte first. Writes appear on a register-file write port as a one-cycle strobe. Reads fetch words through a combinational read port and shift them out to the master.

Bursts are supported in both directions. While the auto-increment control input is high, the register address steps by one after every complete word. While it is low, every word in the burst goes to the same register. A read-disable input makes the slave write-only. A clock-gating rule drops register writes while the system clock is reported absent. The rule is active only while the gating-enable input is high, and a write to the clock-configuration register is always accepted.

The register port carries no back-pressure. The write strobe is a single cycle with no ready signal, so the register file must accept every strobe. The read data must be valid combinationally for the address presented on `reg_rd_addr`. The data line is driven through `sda_oe`, where 1 pulls the line low.

Top module: `i2c_cfg_slave`

## Requirements
- R1: A stop condition (data rising while the clock is high) returns the slave to idle from any state, with `sda_oe` low. A word that was only partly received at that point is never written.
- R2: A first byte whose upper seven bits equal DEV_ADDR (default 7'h4A, so 8'h94 for a write) is acknowledged by driving the data line low during the ninth clock.
- R3: A first byte with any other address gets no acknowledge. The slave then ignores all further bytes until the next start, and it writes nothing.
- R4: While `rd_block` is 1, a first byte with the read/write bit (bit 0) set to 1 gets no acknowledge.
- R5: A write is the device byte, then a register address byte, then the data high byte, then the data low byte, with each byte acknowledged. A one-cycle `reg_wr_en` pulse carrying the address and the word follows the acknowledge of the low byte.
- R6: In a burst write with `cfg_auto_inc`=1, each next word goes to the next register address. With `cfg_auto_inc`=0, all words go to the same register.
- R7: A read sets the address with a write, then a repeated start and a device byte with bit 0 = 1. The slave then sends the addressed word, high byte first, most significant bit first. After a master non-acknowledge it releases the data line.
- R8: In a burst read with `cfg_auto_inc`=1, each word the master acknowledges is followed by the word at the next register address.
- R9: While `cfg_clkgate_en`=1 and `sysclk_present`=0, writes are dropped, although they are still acknowledged. Writes to CLKCFG_ADDR (default 8'h08) are never dropped. With `cfg_clkgate_en`=0, writes are accepted whatever the value of `sysclk_present`.
- R10: `sda_oe` changes only while the synchronised clock line is low, apart from the release on a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| rd_block | input | 1 | 1 makes the port write-only |
| cfg_auto_inc | input | 1 | 1 steps the register address after each word |
| cfg_clkgate_en | input | 1 | 1 makes writes depend on `sysclk_present` |
| sysclk_present | input | 1 | 1 when the system clock is running |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 8 | Register write address |
| reg_wr_data | output | DATA_W | Register write data |
| reg_rd_addr | output | 8 | Register read address |
| reg_rd_data | input | DATA_W | Register read data, combinational from `reg_rd_addr` |

## Verification
The bench uses the default parameters: DEV_ADDR 7'h4A, two-byte words (DATA_W 16), two synchroniser stages and CLKCFG_ADDR 8'h08. The master holds each quarter of a serial clock period for ten system clocks, which leaves room for the synchroniser and edge-detect latency before each data change. With these defaults the 0x94/0x95 address bytes exercise both the match and the read/write-bit handling. The bench also checks the high-byte-first ordering, address stepping across bursts in both directions, the configuration-register exemption from write gating, and the discard of a half-received word at a stop.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int REG_AW = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_RX_END,
    S_ACK,
    S_TX,
    S_MACK,
    S_MACK_END
  } st_e;

  typedef enum logic [1:0] {
    P_DEV,
    P_REG,
    P_DATA
  } ph_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic ff [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ff[0] <= 1'b1;
        else        ff[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ff[i] <= 1'b1;
        else        ff[i] <= ff[i-1];
    end
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/i2cs_linemon.sv
module i2cs_linemon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h4A,
  parameter int                DATA_W      = 16,
  parameter logic [REG_AW-1:0] CLKCFG_ADDR = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic              sda_s,
  input  logic              rd_block,
  input  logic              cfg_auto_inc,
  input  logic              cfg_clkgate_en,
  input  logic              sysclk_present,
  input  logic [DATA_W-1:0] rd_data,
  output logic [REG_AW-1:0] rd_addr,
  output logic              wr_en,
  output logic [REG_AW-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam int BPW = DATA_W / 8;
  localparam int BIW = (BPW > 1) ? $clog2(BPW) : 1;
  localparam logic [BIW-1:0] LAST_BYTE = BIW'(BPW - 1);

  st_e               st;
  ph_e               ph;
  logic              rnw, mnack;
  logic [2:0]        bitcnt;
  logic [7:0]        sh;
  logic [BIW-1:0]    byte_idx;
  logic [REG_AW-1:0] reg_addr;
  logic [DATA_W-1:0] wacc, txw;
  logic              accept, dev_hit;

  assign accept  = sysclk_present | ~cfg_clkgate_en | (reg_addr == CLKCFG_ADDR);
  assign dev_hit = (sh[7:1] == DEV_ADDR) && !(sh[0] && rd_block);
  assign rd_addr = reg_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= P_DEV;
      rnw      <= 1'b0;
      mnack    <= 1'b0;
      bitcnt   <= '0;
      sh       <= '0;
      byte_idx <= '0;
      reg_addr <= '0;
      wacc     <= '0;
      txw      <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      sda_oe   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_c) begin
        st     <= S_RX;
        ph     <= P_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          S_IDLE: ;
          S_RX: if (scl_rise) begin
            sh <= {sh[6:0], sda_s};
            if (bitcnt == 3'd7) st <= S_RX_END;
            else                bitcnt <= bitcnt + 3'd1;
          end
          S_RX_END: if (scl_fall) begin
            bitcnt <= '0;
            unique case (ph)
              P_DEV: begin
                if (dev_hit) begin
                  rnw    <= sh[0];
                  sda_oe <= 1'b1;
                  st     <= S_ACK;
                end else begin
                  st <= S_IDLE;
                end
              end
              P_REG: begin
                reg_addr <= sh;
                byte_idx <= '0;
                sda_oe   <= 1'b1;
                st       <= S_ACK;
              end
              default: begin
                wacc   <= (wacc << 8) | {{(DATA_W-8){1'b0}}, sh};
                sda_oe <= 1'b1;
                st     <= S_ACK;
              end
            endcase
          end
          S_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            unique case (ph)
              P_DEV: begin
                if (rnw) begin
                  txw      <= rd_data;
                  sda_oe   <= ~rd_data[DATA_W-1];
                  byte_idx <= '0;
                  st       <= S_TX;
                end else begin
                  ph <= P_REG;
                  st <= S_RX;
                end
              end
              P_REG: begin
                ph <= P_DATA;
                st <= S_RX;
              end
              default: begin
                st <= S_RX;
                if (byte_idx == LAST_BYTE) begin
                  byte_idx <= '0;
                  wr_en    <= accept;
                  wr_addr  <= reg_addr;
                  wr_data  <= wacc;
                  if (cfg_auto_inc) reg_addr <= reg_addr + 8'd1;
                end else begin
                  byte_idx <= byte_idx + 1'b1;
                end
              end
            endcase
          end
          S_TX: if (scl_fall) begin
            txw <= txw << 1;
            if (bitcnt == 3'd7) begin
              sda_oe <= 1'b0;
              st     <= S_MACK;
            end else begin
              sda_oe <= ~txw[DATA_W-2];
              bitcnt <= bitcnt + 3'd1;
            end
          end
          S_MACK: if (scl_rise) begin
            mnack <= sda_s;
            st    <= S_MACK_END;
            if (!sda_s && byte_idx == LAST_BYTE && cfg_auto_inc)
              reg_addr <= reg_addr + 8'd1;
          end
          S_MACK_END: if (scl_fall) begin
            bitcnt <= '0;
            if (mnack) begin
              st <= S_IDLE;
            end else begin
              st <= S_TX;
              if (byte_idx == LAST_BYTE) begin
                byte_idx <= '0;
                txw      <= rd_data;
                sda_oe   <= ~rd_data[DATA_W-1];
              end else begin
                byte_idx <= byte_idx + 1'b1;
                sda_oe   <= ~txw[DATA_W-1];
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2cs_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h4A,
  parameter int                DATA_W      = 16,
  parameter int                SYNC_STAGES = 2,
  parameter logic [REG_AW-1:0] CLKCFG_ADDR = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              rd_block,
  input  logic              cfg_auto_inc,
  input  logic              cfg_clkgate_en,
  input  logic              sysclk_present,
  output logic              reg_wr_en,
  output logic [REG_AW-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic [REG_AW-1:0] reg_rd_addr,
  input  logic [DATA_W-1:0] reg_rd_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  i2cs_linemon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c));

  i2cs_ctrl #(
    .DEV_ADDR(DEV_ADDR), .DATA_W(DATA_W), .CLKCFG_ADDR(CLKCFG_ADDR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c), .sda_s(sda_s),
    .rd_block(rd_block), .cfg_auto_inc(cfg_auto_inc),
    .cfg_clkgate_en(cfg_clkgate_en), .sysclk_present(sysclk_present),
    .rd_data(reg_rd_data), .rd_addr(reg_rd_addr),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .sda_oe(sda_oe));
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
  parameter logic [7:0] CLKCFG_ADDR = 8'h08
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       start_c,
  input logic       stop_c,
  input logic       reg_wr_en,
  input logic [7:0] reg_wr_addr,
  input logic       sysclk_present,
  input logic       cfg_clkgate_en
);
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (!sda_oe && !reg_wr_en)); // R1

  AST_START_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> !reg_wr_en); // R1

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en); // R5

  AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> ($past(sysclk_present) || !$past(cfg_clkgate_en)
                   || reg_wr_addr == CLKCFG_ADDR)); // R9

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_c) && !$past(stop_c)) |-> !$past(scl_s)); // R10
endmodule

bind i2c_cfg_slave i2cs_checker #(.CLKCFG_ADDR(CLKCFG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .start_c(start_c), .stop_c(stop_c), .reg_wr_en(reg_wr_en),
  .reg_wr_addr(reg_wr_addr), .sysclk_present(sysclk_present),
  .cfg_clkgate_en(cfg_clkgate_en));

// File: tb/sim_i2c_cfg_slave.sv
`timescale 1ns/1ps
module sim_i2c_cfg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic rd_block = 1'b0, cfg_auto_inc = 1'b1, cfg_clkgate_en = 1'b1, sysclk_present = 1'b1;
  logic sda_oe, reg_wr_en;
  logic [7:0] reg_wr_addr, reg_rd_addr;
  logic [15:0] reg_wr_data, reg_rd_data;
  logic sda_line;
  logic [15:0] mem [256];

  int checks = 0, errors = 0, r10_bad = 0;
  logic [23:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_cfg_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .rd_block(rd_block), .cfg_auto_inc(cfg_auto_inc), .cfg_clkgate_en(cfg_clkgate_en),
    .sysclk_present(sysclk_present), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data));

  always @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 16'h0;
    end else if (reg_wr_en) begin
      mem[reg_wr_addr] <= reg_wr_data;
    end
  assign reg_rd_data = mem[reg_rd_addr];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every strobe must match the oldest expected write (R5, R6, R9)
  always @(negedge clk)
    if (rst_n && reg_wr_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3/R9", "unexpected write", {reg_wr_addr, reg_wr_data}, 0);
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk({reg_wr_addr, reg_wr_data} == e, "R5/R6", "write addr+data",
            {reg_wr_addr, reg_wr_data}, e);
      end
    end

  // R10 monitor: slave data changes must fall while the master holds the clock low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) r10_bad++;
    oe_prev = sda_oe;
  end

  task automatic tk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tk(Q); scl_m = 1'b1; tk(Q);
    sda_m = 1'b0; tk(Q); scl_m = 1'b0; tk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tk(Q); scl_m = 1'b1; tk(Q); sda_m = 1'b1; tk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tk(Q); scl_m = 1'b1; tk(2*Q); scl_m = 1'b0; tk(Q);
    end
    sda_m = 1'b1; tk(Q); scl_m = 1'b1; tk(Q);
    ack = ~sda_line;
    tk(Q); scl_m = 1'b0; tk(Q);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tk(Q); scl_m = 1'b1; tk(Q); b[i] = sda_line; tk(Q); scl_m = 1'b0;
    end
    tk(Q); sda_m = nack; tk(Q); scl_m = 1'b1; tk(2*Q); scl_m = 1'b0; tk(Q);
    sda_m = 1'b1;
  endtask

  task automatic wr_head(input logic [7:0] ra, input string req);
    bit a;
    bus_start();
    send_byte(8'h94, a); chk(a, "R2", {req, " device ack"}, a, 1);
    send_byte(ra, a);    chk(a, "R5", {req, " reg addr ack"}, a, 1);
  endtask

  task automatic wr_word(input logic [15:0] w, input string req);
    bit a;
    send_byte(w[15:8], a); chk(a, "R5", {req, " high byte ack"}, a, 1);
    send_byte(w[7:0], a);  chk(a, "R5", {req, " low byte ack"}, a, 1);
  endtask

  task automatic rd_head(input logic [7:0] ra);
    bit a;
    wr_head(ra, "R7 read setup");
    bus_start();
    send_byte(8'h95, a); chk(a, "R7", "read device ack", a, 1);
  endtask

  task automatic rd_word(input bit last, output logic [15:0] w);
    logic [7:0] hi, lo;
    recv_byte(1'b0, hi);
    recv_byte(last, lo);
    w = {hi, lo};
  endtask

  initial begin
    logic [15:0] w;
    bit a;
    tk(5); rst_n = 1'b1; tk(5);
    @(negedge clk);
    chk(sda_oe == 1'b0, "R1", "reset sda_oe", sda_oe, 0);
    chk(reg_wr_en == 1'b0, "R1", "reset reg_wr_en", reg_wr_en, 0);

    // R2 R5 single write
    exp_q.push_back({8'h10, 16'hBEEF});
    wr_head(8'h10, "R5 single"); wr_word(16'hBEEF, "R5 single"); bus_stop();

    // R6 burst write with auto-increment
    exp_q.push_back({8'h20, 16'h1111});
    exp_q.push_back({8'h21, 16'h2222});
    exp_q.push_back({8'h22, 16'h3333});
    wr_head(8'h20, "R6 inc");
    wr_word(16'h1111, "R6"); wr_word(16'h2222, "R6"); wr_word(16'h3333, "R6");
    bus_stop();

    // R6 burst write without auto-increment
    cfg_auto_inc = 1'b0;
    exp_q.push_back({8'h30, 16'hAAAA});
    exp_q.push_back({8'h30, 16'h5A5A});
    wr_head(8'h30, "R6 noinc"); wr_word(16'hAAAA, "R6"); wr_word(16'h5A5A, "R6");
    bus_stop();
    cfg_auto_inc = 1'b1;

    // R3 mismatched address: no ack, later bytes ignored
    bus_start();
    send_byte(8'h96, a); chk(!a, "R3", "mismatch device nack", a, 0);
    send_byte(8'h10, a); chk(!a, "R3", "mismatch later byte nack", a, 0);
    send_byte(8'h12, a); chk(!a, "R3", "mismatch data byte nack", a, 0);
    bus_stop();

    // R7 single read, also shows R3 left register 0x10 intact
    rd_head(8'h10); rd_word(1'b1, w);
    chk(w == 16'hBEEF, "R7", "single read word (R3 untouched)", w, 16'hBEEF);
    chk(sda_oe == 1'b0, "R7", "released after nack", sda_oe, 0);
    bus_stop();

    // R8 burst read with auto-increment
    rd_head(8'h20);
    rd_word(1'b0, w); chk(w == 16'h1111, "R8", "burst word0", w, 16'h1111);
    rd_word(1'b0, w); chk(w == 16'h2222, "R8", "burst word1", w, 16'h2222);
    rd_word(1'b1, w); chk(w == 16'h3333, "R8", "burst word2", w, 16'h3333);
    bus_stop();

    // R6 no-increment result: register 0x30 holds the last word, 0x31 unwritten
    rd_head(8'h30);
    rd_word(1'b0, w); chk(w == 16'h5A5A, "R6", "noinc target", w, 16'h5A5A);
    cfg_auto_inc = 1'b1;
    rd_word(1'b1, w); chk(w == 16'h0000, "R6", "noinc neighbour", w, 0);
    bus_stop();

    // R4 write-only mode
    rd_block = 1'b1;
    wr_head(8'h10, "R4 setup");
    bus_start();
    send_byte(8'h95, a); chk(!a, "R4", "read nack when blocked", a, 0);
    bus_stop();
    rd_block = 1'b0;

    // R9 clock gating
    sysclk_present = 1'b0;
    wr_head(8'h40, "R9 gated"); wr_word(16'h4444, "R9 gated"); bus_stop();
    exp_q.push_back({8'h08, 16'h0000});
    wr_head(8'h08, "R9 clkcfg"); wr_word(16'h0000, "R9 clkcfg"); bus_stop();
    cfg_clkgate_en = 1'b0;
    exp_q.push_back({8'h41, 16'h5555});
    wr_head(8'h41, "R9 ungated"); wr_word(16'h5555, "R9 ungated"); bus_stop();
    sysclk_present = 1'b1; cfg_clkgate_en = 1'b1;
    rd_head(8'h40);
    rd_word(1'b0, w); chk(w == 16'h0000, "R9", "gated write dropped", w, 0);
    rd_word(1'b1, w); chk(w == 16'h5555, "R9", "ungated write kept", w, 16'h5555);
    bus_stop();

    // R1 stop in the middle of a word
    wr_head(8'h50, "R1 abort");
    send_byte(8'hCC, a); chk(a, "R1", "abort high byte ack", a, 1);
    bus_stop();
    rd_head(8'h50); rd_word(1'b1, w);
    chk(w == 16'h0000, "R1", "partial word not written", w, 0);
    bus_stop();

    tk(20);
    chk(exp_q.size() == 0, "R5", "all expected writes seen", exp_q.size(), 0);
    chk(r10_bad == 0, "R10", "sda changes while scl high", r10_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule